// File: doc/BRIEF.md
# Cache Line Push and Invalidate Engine

This block carries out maintenance operations on a four-way set-associative cache directory. Software hands it a 32-bit operand that names a set and a way directly. The block does no tag lookup. If the named line holds modified data, the engine writes that line back through a valid/ready memory port. A per-command mode bit then decides what happens to the line: it is either invalidated, or left valid and marked clean.

A second command clears the valid and modified bits of every line. It runs as a sweep that clears one set per clock cycle. Software must issue it before the cache is first turned on.

The directory and data arrays sit outside the engine. The engine reads them combinationally through a set/way select. It writes them back through a per-line state strobe and a whole-set clear strobe. Any cache-enable setting elsewhere in the system has no path into this block, so maintenance works the same whether the cache is on or off.

Top module: `cache_push_engine`

## Requirements
- R1: A push operand carries the set number in bits 11:4 and the way number in bits 3:0. A push to a valid, modified line issues exactly one write-back of that line.
- R2: The write-back address is the line's stored tag, followed by its set number, followed by four zero bits. The write-back data is the line's 128 bits, word 0 in bits 31:0. Address and data stay stable while wb_valid is high and wb_ready is low.
- R3: With cmd_keep = 0, a pushed valid line ends invalid and clean.
- R4: With cmd_keep = 1, a pushed valid line ends valid and clean.
- R5: A push to an invalid line, or to a valid clean line, makes no write-back and raises done in the cycle after acceptance. A clean line is still invalidated when cmd_keep = 0.
- R6: A push whose way field exceeds 3, whose set field is 128 or above, or whose bits 31:12 are not all zero is a no-op. It writes no line state, makes no write-back, and raises done in the cycle after acceptance.
- R7: An invalidate-all command (cmd_op = 1) clears every set, one per cycle, in ascending order from set 0. busy stays high for exactly 128 cycles. done rises in the cycle after the last set is cleared.
- R8: cmd_ready is low while a write-back or a sweep is in progress. A command offered then is not taken.
- R9: After reset, cmd_ready = 1 and busy, done, wb_valid, st_we and clr_we are all 0.
- R10: done is high for one cycle directly after the write-back handshake completes, and wb_valid is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 1 | 0 = push one line, 1 = invalidate all |
| cmd_operand | input | 32 | Set/way operand for a push |
| cmd_keep | input | 1 | 1 = keep the pushed line valid |
| busy | output | 1 | Write-back or sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| dir_set | output | 7 | Set selected on the array port |
| dir_way | output | 2 | Way selected on the array port |
| dir_tag | input | 21 | Tag of the selected line |
| dir_valid | input | 1 | Valid bit of the selected line |
| dir_dirty | input | 1 | Modified bit of the selected line |
| dir_data | input | 128 | Data of the selected line |
| st_we | output | 1 | Write st_valid/st_dirty to the selected line |
| st_valid | output | 1 | New valid bit |
| st_dirty | output | 1 | New modified bit |
| clr_we | output | 1 | Clear all ways of dir_set |
| wb_valid | output | 1 | Write-back offered |
| wb_ready | input | 1 | Memory takes the write-back |
| wb_addr | output | 32 | Write-back line address |
| wb_data | output | 128 | Write-back line data |

## Verification
A wrongly decoded set or way shows up at once as a write-back to the wrong address, with data from another line. It also leaves a modified line in the array after that push's done pulse. A wrong end state in the line update is visible as soon as the push completes, because the line's valid and modified bits no longer match the chosen mode. A sweep counter that skips, stalls or runs long shows as a wrong set number on the clear strobe within one cycle, or as a busy interval other than 128 cycles. A write-back that is dropped or issued twice changes the count of wb_valid handshakes on the same push.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
    localparam int OPND_W       = 32;
    localparam int OPND_WAY_LSB = 0;
    localparam int OPND_WAY_W   = 4;
    localparam int OPND_SET_LSB = 4;
    localparam int OPND_SET_W   = 8;
    localparam int OPND_RSV_LSB = OPND_SET_LSB + OPND_SET_W;
    localparam int WORD_W       = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_SWEEP = 2'd2
    } eng_state_e;

    typedef enum logic {
        OP_PUSH    = 1'b0,
        OP_INV_ALL = 1'b1
    } cmd_op_e;

    function automatic logic rsv_clear(input logic [OPND_W-1:0] op);
        return op[OPND_W-1:OPND_RSV_LSB] == '0;
    endfunction
endpackage

// File: rtl/cpe_decode.sv
module cpe_decode
    import cpe_pkg::*;
#(
    parameter int NUM_SETS = 128,
    parameter int WAYS     = 4,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic [OPND_W-1:0] operand,
    output logic [SET_W-1:0]  set_idx,
    output logic [WAY_W-1:0]  way_idx,
    output logic              legal
);
    logic [OPND_SET_W-1:0] set_field;
    logic [OPND_WAY_W-1:0] way_field;

    always_comb begin
        set_field = operand[OPND_SET_LSB +: OPND_SET_W];
        way_field = operand[OPND_WAY_LSB +: OPND_WAY_W];
        set_idx   = set_field[SET_W-1:0];
        way_idx   = way_field[WAY_W-1:0];
        legal     = rsv_clear(operand)
                    && (32'(set_field) < NUM_SETS)
                    && (32'(way_field) < WAYS);
    end
endmodule

// File: rtl/cpe_sweep.sv
module cpe_sweep #(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active,
    output logic [SET_W-1:0] set_idx,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            set_idx <= '0;
        end else if (start) begin
            active  <= 1'b1;
            set_idx <= '0;
        end else if (active) begin
            if (set_idx == LAST_SET) active <= 1'b0;
            else                     set_idx <= set_idx + 1'b1;
        end
    end

    assign last = active && (set_idx == LAST_SET);

    // R7: the clear strobe walks the sets one step per cycle
    a_r7_sweep_step: assert property (@(posedge clk) disable iff (rst)
        active && $past(active) && !$past(last) |-> set_idx == $past(set_idx) + 1'b1);
    a_r7_sweep_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> set_idx == '0);
endmodule

// File: rtl/cache_push_engine.sv
module cache_push_engine
    import cpe_pkg::*;
#(
    parameter int NUM_SETS   = 128,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32,
    localparam int SET_W     = $clog2(NUM_SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int OFF_W     = $clog2(LINE_WORDS * (WORD_W / 8)),
    localparam int TAG_W     = ADDR_W - SET_W - OFF_W,
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [31:0]       cmd_operand,
    input  logic              cmd_keep,
    output logic              busy,
    output logic              done,
    output logic [SET_W-1:0]  dir_set,
    output logic [WAY_W-1:0]  dir_way,
    input  logic [TAG_W-1:0]  dir_tag,
    input  logic              dir_valid,
    input  logic              dir_dirty,
    input  logic [LINE_W-1:0] dir_data,
    output logic              st_we,
    output logic              st_valid,
    output logic              st_dirty,
    output logic              clr_we,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    eng_state_e        state;
    logic [SET_W-1:0]  dec_set, f_set, sw_set;
    logic [WAY_W-1:0]  dec_way, f_way;
    logic              dec_legal, f_keep;
    logic              accept, push_go, sweep_go, sw_active, sw_last;
    logic              need_flush;

    cpe_decode #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_decode (
        .operand (cmd_operand),
        .set_idx (dec_set),
        .way_idx (dec_way),
        .legal   (dec_legal)
    );

    cpe_sweep #(.NUM_SETS(NUM_SETS)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .start   (sweep_go),
        .active  (sw_active),
        .set_idx (sw_set),
        .last    (sw_last)
    );

    assign busy       = (state != ST_IDLE);
    assign cmd_ready  = !busy;
    assign accept     = cmd_valid && cmd_ready;
    assign push_go    = accept && (cmd_op_e'(cmd_op) == OP_PUSH) && dec_legal;
    assign sweep_go   = accept && (cmd_op_e'(cmd_op) == OP_INV_ALL);
    assign need_flush = dir_valid && dir_dirty;
    assign wb_valid   = (state == ST_FLUSH);
    assign clr_we     = (state == ST_SWEEP) && sw_active;

    always_comb begin
        dir_set  = dec_set;
        dir_way  = dec_way;
        st_we    = 1'b0;
        st_valid = 1'b0;
        st_dirty = 1'b0;
        unique case (state)
            ST_FLUSH: begin
                dir_set  = f_set;
                dir_way  = f_way;
                st_we    = wb_ready;
                st_valid = f_keep;
            end
            ST_SWEEP: dir_set = sw_set;
            default:  st_we = push_go && dir_valid && !dir_dirty && !cmd_keep;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            f_set   <= '0;
            f_way   <= '0;
            f_keep  <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sweep_go) begin
                        state <= ST_SWEEP;
                    end else if (push_go && need_flush) begin
                        state   <= ST_FLUSH;
                        f_set   <= dec_set;
                        f_way   <= dec_way;
                        f_keep  <= cmd_keep;
                        wb_addr <= {dir_tag, dec_set, {OFF_W{1'b0}}};
                        wb_data <= dir_data;
                    end else if (accept) begin
                        done <= 1'b1;
                    end
                end
                ST_FLUSH: if (wb_ready) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                ST_SWEEP: if (sw_last) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: an offered write-back is held unchanged until taken
    a_r2_wb_hold: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));
    // R5: a write-back only follows a push of a valid modified line
    a_r5_wb_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_valid) |-> $past(accept && dir_valid && dir_dirty));
    // R6: an illegal push completes next cycle without a write-back
    a_r6_illegal_noop: assert property (@(posedge clk) disable iff (rst)
        accept && !cmd_op && !dec_legal |=> done && !wb_valid);
    a_r6_illegal_nowrite: assert property (@(posedge clk) disable iff (rst)
        accept && !cmd_op && !dec_legal |-> !st_we);
    // R7: set clear and line update never share a cycle
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(st_we && clr_we));
    // R8: no command is taken while a write-back or sweep runs
    a_r8_no_accept: assert property (@(posedge clk) disable iff (rst)
        (wb_valid || clr_we) |-> !cmd_ready);
    // R10: completion pulse follows the handshake
    a_r10_done_after_wb: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_ready |=> done && !wb_valid);
endmodule

// File: tb/cache_push_engine_tb.sv
module cache_push_engine_tb;
    localparam int NS = 128;
    localparam int NW = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0, cmd_op = 1'b0, cmd_keep = 1'b0;
    logic [31:0]  cmd_operand = '0;
    logic         cmd_ready, busy, done;
    logic [6:0]   dir_set;
    logic [1:0]   dir_way;
    logic [20:0]  dir_tag;
    logic         dir_valid, dir_dirty;
    logic [127:0] dir_data;
    logic         st_we, st_valid, st_dirty, clr_we;
    logic         wb_valid, wb_ready = 1'b0;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;

    logic         mv [NS][NW];
    logic         md [NS][NW];
    logic [20:0]  mt [NS][NW];
    logic [127:0] mdat [NS][NW];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cache_push_engine u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_operand(cmd_operand), .cmd_keep(cmd_keep),
        .busy(busy), .done(done), .dir_set(dir_set), .dir_way(dir_way),
        .dir_tag(dir_tag), .dir_valid(dir_valid), .dir_dirty(dir_dirty),
        .dir_data(dir_data), .st_we(st_we), .st_valid(st_valid),
        .st_dirty(st_dirty), .clr_we(clr_we), .wb_valid(wb_valid),
        .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    assign dir_valid = mv[dir_set][dir_way];
    assign dir_dirty = md[dir_set][dir_way];
    assign dir_tag   = mt[dir_set][dir_way];
    assign dir_data  = mdat[dir_set][dir_way];

    always @(posedge clk) begin
        if (st_we) begin
            mv[dir_set][dir_way] <= st_valid;
            md[dir_set][dir_way] <= st_dirty;
        end
        if (clr_we) begin
            for (int w = 0; w < NW; w++) begin
                mv[dir_set][w] <= 1'b0;
                md[dir_set][w] <= 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [127:0] line_data(int s, int w);
        logic [127:0] d;
        for (int i = 0; i < 4; i++) d[i*32 +: 32] = {8'(s), 8'(w), 8'(i), 8'hA5};
        return d;
    endfunction

    task automatic fill(input bit all_dirty);
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                mt[s][w]   = 21'((s * 4 + w) * 37 + 5);
                mdat[s][w] = line_data(s, w);
                mv[s][w]   = all_dirty ? 1'b1 : ((s + w) % 3 != 0);
                md[s][w]   = all_dirty ? 1'b1 : (mv[s][w] && ((s * w) % 2 == 1 || w == 3));
            end
        end
    endtask

    task automatic issue(input logic op, input logic [31:0] opnd, input logic keep);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_operand = opnd; cmd_keep = keep;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // push of an in-range line with full expectation
    task automatic push_line(input int s, input int w, input logic keep, input int hold);
        logic ev, ed, xv, xd;
        logic [31:0] ea;
        ev = mv[s][w]; ed = md[s][w];
        ea = {mt[s][w], 7'(s), 4'b0000};
        issue(1'b0, {20'b0, 8'(s), 4'(w)}, keep);
        if (ev && ed) begin
            check(wb_valid === 1'b1, $sformatf("R1 s%0d w%0d wb_valid act=%b exp=1", s, w, wb_valid));
            check(wb_addr === ea, $sformatf("R2 s%0d w%0d addr act=%h exp=%h", s, w, wb_addr, ea));
            check(wb_data === mdat[s][w], $sformatf("R2 s%0d w%0d data act=%h exp=%h", s, w, wb_data, mdat[s][w]));
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(wb_valid === 1'b1 && wb_addr === ea && done === 1'b0,
                      $sformatf("R2 s%0d hold v=%b addr=%h exp=%h", s, wb_valid, wb_addr, ea));
                check(cmd_ready === 1'b0, $sformatf("R8 ready in flush act=%b exp=0", cmd_ready));
            end
            wb_ready = 1'b1;
            @(negedge clk);
            wb_ready = 1'b0;
            check(done === 1'b1 && wb_valid === 1'b0,
                  $sformatf("R10 s%0d w%0d done=%b wb_valid=%b exp 1/0", s, w, done, wb_valid));
        end else begin
            check(done === 1'b1 && wb_valid === 1'b0,
                  $sformatf("R5 s%0d w%0d done=%b wb_valid=%b exp 1/0", s, w, done, wb_valid));
        end
        xv = ev && keep; xd = 1'b0;
        if (keep) check(mv[s][w] === xv && md[s][w] === xd,
                  $sformatf("R4 s%0d w%0d state act=%b%b exp=%b%b", s, w, mv[s][w], md[s][w], xv, xd));
        else      check(mv[s][w] === xv && md[s][w] === xd,
                  $sformatf("R3 s%0d w%0d state act=%b%b exp=%b%b", s, w, mv[s][w], md[s][w], xv, xd));
    endtask

    task automatic noop_push(input logic [31:0] opnd, input int s, input int w, input string tag);
        issue(1'b0, opnd, 1'b0);
        check(done === 1'b1 && wb_valid === 1'b0,
              $sformatf("R6 %s done=%b wb_valid=%b exp 1/0", tag, done, wb_valid));
        check(mv[s][w] === 1'b1 && md[s][w] === 1'b1,
              $sformatf("R6 %s line s%0d w%0d act=%b%b exp=11", tag, s, w, mv[s][w], md[s][w]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int bcnt;
        bit order_ok;
        fill(1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && wb_valid === 1'b0
              && st_we === 1'b0 && clr_we === 1'b0,
              $sformatf("R9 reset ready=%b busy=%b done=%b wbv=%b exp 1000",
                        cmd_ready, busy, done, wb_valid));

        // R6 no-op operands against a dirty line
        mv[5][1] = 1'b1; md[5][1] = 1'b1;
        noop_push({20'b0, 8'd5, 4'd5}, 5, 1, "way5");
        noop_push({20'b0, 8'd5, 4'd15}, 5, 1, "way15");
        noop_push({20'b0, 8'd133, 4'd1}, 5, 1, "set133");
        noop_push({11'b0, 1'b1, 8'b0, 8'd5, 4'd1}, 5, 1, "rsv20");

        // R1..R5: every line of the cache, mode alternating by set
        fill(1'b0);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                push_line(s, w, 1'(s % 2), s % 3);

        // R5: second pass, everything is now clean or invalid
        for (int w = 0; w < NW; w++) push_line(9, w, 1'b0, 0);

        // R7, R8: invalidate-all with a push offered mid-sweep
        fill(1'b1);
        issue(1'b1, 32'h0, 1'b0);
        bcnt = 0;
        order_ok = 1'b1;
        while (busy === 1'b1 && bcnt < 1000) begin
            if (!(clr_we === 1'b1 && dir_set === 7'(bcnt))) order_ok = 1'b0;
            if (bcnt == 20) begin
                check(cmd_ready === 1'b0, $sformatf("R8 ready mid-sweep act=%b exp=0", cmd_ready));
                cmd_valid = 1'b1; cmd_op = 1'b0; cmd_operand = {20'b0, 8'd100, 4'd0};
            end
            if (bcnt == 30) cmd_valid = 1'b0;
            bcnt++;
            @(negedge clk);
            if (bcnt < 128 && done === 1'b1) order_ok = 1'b0;
        end
        check(order_ok, "R7 sweep order or early done");
        check(bcnt == 128, $sformatf("R7 busy cycles act=%0d exp=128", bcnt));
        check(done === 1'b1, $sformatf("R7 done after sweep act=%b exp=1", done));
        @(negedge clk);
        check(wb_valid === 1'b0 && done === 1'b0,
              $sformatf("R8 offered push taken: wbv=%b done=%b exp 0/0", wb_valid, done));
        begin
            int left = 0;
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++)
                    if (mv[s][w] !== 1'b0 || md[s][w] !== 1'b0) left++;
            check(left == 0, $sformatf("R7 lines not cleared act=%0d exp=0", left));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule